// File: doc/BRIEF.md
# Display Pipe Interrupt Aggregator with Edge-Captured Identity Bits

This block gathers per-pipe display events into a single interrupt line. Each pipe owns one status/enable register. Its status bits are sticky: a one-cycle event pulse sets them, and software clears them by writing ones. Its enable bits choose which of those status bits count. Each pipe also has a live summary bit, which is high while any status bit and its matching enable are both set. The summary bits together form the live status word (ISR).

An identity register (IIR) captures the summary bits. A parameter picks how it captures them. In edge mode, an identity bit is set only on a low-to-high transition of its summary bit. In level mode, an identity bit is set on every cycle its summary bit is high. Software clears identity bits by writing ones. A mask register gates the identity bits onto a registered interrupt output.

In edge mode a pending event can be lost. Software may acknowledge the status bits while a new enabled event keeps the summary high, and then clear the identity bit. The result is an identity bit of zero with a live summary bit of one. To re-arm the bit, software must write the status acknowledge with all enables at zero and then restore the enables. The block reproduces both behaviours exactly.

Register access uses plain read and write strobes. These are control pins, not a stream, so there is no back-pressure: every access completes in the cycle its strobe is high.

Top module: `pipe_irq_agg`

## Requirements
- R1: A one-cycle pulse on `evt_i[p*8+b]` sets status bit b of pipe p at the next clock edge. The bit then stays set until software clears it.
- R2: A write to a pipe register clears each status bit whose `wr_data[7:0]` bit is one and leaves the other status bits unchanged. If an event pulse arrives in the same cycle as a clear of that bit, the bit stays set.
- R3: Pipe p's register sits at word address p. Its enables are bits 23:16 and its status bits are bits 7:0. A single write loads the enables and applies the status clear together, and a read returns both fields.
- R4: The live status word at address 2 has bit p high exactly when pipe p has at least one status bit set whose enable is also set.
- R5: In edge mode (`EDGE_MODE=1`), identity bit p is set only when live bit p goes from low to high. If live bit p stays high, a cleared identity bit is not set again.
- R6: The identity register sits at address 3. Writing a one to bit p clears identity bit p. If the set condition holds in the same cycle as the clear, the bit stays set.
- R7: Edge mode, lost-interrupt sequence: read the status, then a new enabled event arrives, then the register is written with its enables plus the old status, then the identity bit is cleared. This sequence leaves identity bit p at 0 while live bit p stays at 1.
- R8: Edge mode, re-arm: writing the status acknowledge with all enables zero drives live bit p low. A following write that restores the enables, with an enabled status bit still set, sets identity bit p again.
- R9: In level mode (`EDGE_MODE=0`), identity bit p is set on every cycle in which live bit p is high, even right after it was cleared.
- R10: The mask register sits at address 4; a one in bit p masks pipe p. `irq_o` equals the OR of the identity bits that are not masked, delayed by one clock.
- R11: A read captures the addressed register into `rd_data` at the clock edge where `rd_en` is high, and `rd_data` holds that value until the next read. Reads change no state.
- R12: A synchronous active-high reset sets every status, enable, identity and mask bit to zero, and sets `irq_o` and `rd_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 16 | One-cycle event pulses, 8 per pipe, pipe p at bits p*8+7:p*8 |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data, registered |
| irq_o | output | 1 | Interrupt output, registered |

## Verification
The bench replays the acknowledge race step by step. A design that re-captured a steady live bit would show the identity bit set where it must read zero. It then runs the enable drop-and-restore sequence. A design without a true edge detector, or one that ignored the enables in the summary, would fail to produce a fresh identity bit there. It drives an event pulse in the same cycle as a status clear, and drives a level-mode identity clear while the live bit is high. A design with clear-over-set priority would lose an event in both cases. A level-mode instance runs beside the edge instance to show the two capture policies differ under identical stimulus.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_PIPE = 3'd1,
    SEL_LIVE = 3'd2,
    SEL_IDNT = 3'd3,
    SEL_MASK = 3'd4
  } reg_sel_e;

  // Address map derived from the pipe count: pipes first, then live word,
  // identity word and mask word.
  function automatic reg_sel_e decode_addr(input int unsigned addr,
                                           input int unsigned npipes);
    if (addr < npipes)            return SEL_PIPE;
    else if (addr == npipes)      return SEL_LIVE;
    else if (addr == npipes + 1)  return SEL_IDNT;
    else if (addr == npipes + 2)  return SEL_MASK;
    else                          return SEL_NONE;
  endfunction

endpackage

// File: rtl/pirq_stat_reg.sv
module pirq_stat_reg #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic [STAT_W-1:0] en_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] en_o,
  output logic              summ_o
);

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] en_q;
  logic [STAT_W-1:0] clr_mask;

  assign clr_mask = wr_i ? clr_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | evt_i;
      if (wr_i) en_q <= en_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign summ_o = |(stat_q & en_q);

  // R1
  evt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  // R2
  clr_applies_chk: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> ((stat_q & $past(clr_i & ~evt_i)) == '0));

  // R2
  untouched_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && evt_i == '0) |=> $stable(stat_q));

endmodule

// File: rtl/pirq_ident.sv
module pirq_ident #(
  parameter int NUM_PIPES = 2,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PIPES-1:0] live_i,
  input  logic [NUM_PIPES-1:0] clr_i,
  output logic [NUM_PIPES-1:0] ident_o
);

  logic [NUM_PIPES-1:0] set_v;
  logic [NUM_PIPES-1:0] ident_q;

  generate
    if (EDGE_MODE) begin : g_edge
      logic [NUM_PIPES-1:0] live_d;
      always_ff @(posedge clk) begin
        if (rst) live_d <= '0;
        else     live_d <= live_i;
      end
      assign set_v = live_i & ~live_d;
    end else begin : g_level
      assign set_v = live_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ident_q <= '0;
    else     ident_q <= (ident_q & ~clr_i) | set_v;
  end

  assign ident_o = ident_q;

  generate
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_chk
      // R6
      ident_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i[p] && !live_i[p]) |=> !ident_q[p]);

      if (EDGE_MODE) begin : g_e
        // R5
        edge_only_chk: assert property (@(posedge clk) disable iff (rst)
          $rose(ident_q[p]) |-> ($past(live_i[p]) && !$past(live_i[p], 2)));
        // R5
        rise_capt_chk: assert property (@(posedge clk) disable iff (rst)
          $rose(live_i[p]) |=> ident_q[p]);
      end else begin : g_l
        // R9
        level_reassert_chk: assert property (@(posedge clk) disable iff (rst)
          live_i[p] |=> ident_q[p]);
      end
    end
  endgenerate

endmodule

// File: rtl/pirq_out.sv
module pirq_out #(
  parameter int NUM_PIPES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PIPES-1:0] ident_i,
  input  logic [NUM_PIPES-1:0] mask_i,
  output logic                 irq_o
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(ident_i & ~mask_i);
  end

  assign irq_o = irq_q;

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((ident_i & ~mask_i) != '0) |=> irq_q);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((ident_i & ~mask_i) == '0) |=> !irq_q);

endmodule

// File: rtl/pipe_irq_agg.sv
module pipe_irq_agg
  import pirq_pkg::*;
#(
  parameter int NUM_PIPES = 2,
  parameter int STAT_W    = 8,
  parameter int EN_LSB    = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PIPES*STAT_W-1:0] evt_i,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        irq_o
);

  localparam int ADDR_SPAN = NUM_PIPES + 3;

  initial begin
    if (ADDR_SPAN > (1 << ADDR_W)) $error("address width too small");
    if (EN_LSB + STAT_W > DATA_W)  $error("enable field exceeds data width");
    if (NUM_PIPES > DATA_W)        $error("too many pipes for data width");
  end

  reg_sel_e wsel;
  reg_sel_e rsel;

  assign wsel = decode_addr(32'(wr_addr), NUM_PIPES);
  assign rsel = decode_addr(32'(rd_addr), NUM_PIPES);

  logic [STAT_W-1:0]    stat_w [NUM_PIPES];
  logic [STAT_W-1:0]    en_w   [NUM_PIPES];
  logic [NUM_PIPES-1:0] live;
  logic [NUM_PIPES-1:0] ident;
  logic [NUM_PIPES-1:0] ident_clr;
  logic [NUM_PIPES-1:0] mask_q;
  logic [DATA_W-1:0]    rword;
  logic [DATA_W-1:0]    rd_q;
  logic                 unused_wbits;

  assign unused_wbits = ^wr_data;

  generate
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
      logic wr_this;
      assign wr_this = wr_en && (wsel == SEL_PIPE) && (wr_addr == ADDR_W'(p));

      pirq_stat_reg #(.STAT_W(STAT_W)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt_i[p*STAT_W +: STAT_W]),
        .wr_i   (wr_this),
        .clr_i  (wr_data[STAT_W-1:0]),
        .en_i   (wr_data[EN_LSB +: STAT_W]),
        .stat_o (stat_w[p]),
        .en_o   (en_w[p]),
        .summ_o (live[p])
      );
    end
  endgenerate

  assign ident_clr = (wr_en && wsel == SEL_IDNT) ? wr_data[NUM_PIPES-1:0] : '0;

  pirq_ident #(.NUM_PIPES(NUM_PIPES), .EDGE_MODE(EDGE_MODE)) u_ident (
    .clk     (clk),
    .rst     (rst),
    .live_i  (live),
    .clr_i   (ident_clr),
    .ident_o (ident)
  );

  always_ff @(posedge clk) begin
    if (rst)                            mask_q <= '0;
    else if (wr_en && wsel == SEL_MASK) mask_q <= wr_data[NUM_PIPES-1:0];
  end

  pirq_out #(.NUM_PIPES(NUM_PIPES)) u_out (
    .clk     (clk),
    .rst     (rst),
    .ident_i (ident),
    .mask_i  (mask_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    rword = '0;
    unique case (rsel)
      SEL_PIPE: begin
        for (int i = 0; i < NUM_PIPES; i++) begin
          if (rd_addr == ADDR_W'(i)) begin
            rword[STAT_W-1:0]         = stat_w[i];
            rword[EN_LSB +: STAT_W]   = en_w[i];
          end
        end
      end
      SEL_LIVE: rword[NUM_PIPES-1:0] = live;
      SEL_IDNT: rword[NUM_PIPES-1:0] = ident;
      SEL_MASK: rword[NUM_PIPES-1:0] = mask_q;
      default:  rword = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rword;
  end

  assign rd_data = rd_q;

  // R10
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wsel == SEL_MASK) |=> (mask_q == $past(wr_data[NUM_PIPES-1:0])));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q));

  // R4
  live_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wsel == SEL_PIPE && wr_data[EN_LSB +: STAT_W] == '0)
      |=> !live[wr_addr]);

endmodule

// File: tb/sim_pipe_irq_agg.sv
module sim_pipe_irq_agg;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] evt_i = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rdat0, rdat1;
  logic        irq0, irq1;
  logic [31:0] r0, r1;
  logic [31:0] snap;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pipe_irq_agg #(.EDGE_MODE(1'b1)) u0 (
    .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rdat0),
    .irq_o(irq0));

  pipe_irq_agg #(.EDGE_MODE(1'b0)) u1 (
    .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rdat1),
    .irq_o(irq1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    r0 = rdat0; r1 = rdat1;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    evt_i[idx] = 1'b1;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic wr_with_evt(input logic [2:0] a, input logic [31:0] d, input int idx);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; evt_i[idx] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; evt_i = '0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a));
      chk("R12 reset register edge", r0, 32'h0);
      chk("R12 reset register level", r1, 32'h0);
    end
    chk("R12 reset irq", {31'b0, irq0}, 32'h0);
  endtask

  task automatic t_sticky_and_edge;
    wr(3'd0, 32'h0001_0000);
    pulse(0);
    idle(3);
    rd(3'd0);
    chk("R1 R3 status sticky with enable", r0, 32'h0001_0001);
    rd(3'd2);
    chk("R4 live bit pipe0", r0, 32'h1);
    rd(3'd3);
    chk("R5 identity set on rise", r0, 32'h1);
    chk("R10 irq asserted", {31'b0, irq0}, 32'h1);
    wr(3'd3, 32'h1);
    idle(2);
    rd(3'd3);
    chk("R5 steady live does not reset identity", r0, 32'h0);
    chk("R9 level identity reasserts", r1, 32'h1);
    chk("R6 level set wins over clear", r1, 32'h1);
    chk("R10 irq drops after clear", {31'b0, irq0}, 32'h0);
    chk("R10 level irq stays", {31'b0, irq1}, 32'h1);
  endtask

  task automatic t_toggle;
    wr(3'd0, 32'h0000_0000);
    idle(1);
    rd(3'd2);
    chk("R8 enables zero drop live", r0, 32'h0);
    wr(3'd0, 32'h0001_0000);
    idle(2);
    rd(3'd3);
    chk("R8 restore gives fresh identity", r0, 32'h1);
    wr(3'd0, 32'h0000_0001);
    wr(3'd3, 32'h3);
    idle(2);
    rd(3'd3);
    chk("R6 identity cleared edge", r0, 32'h0);
    chk("R6 identity cleared level", r1, 32'h0);
  endtask

  task automatic t_status_clear;
    @(negedge clk);
    evt_i[3:0] = 4'hF;
    @(negedge clk);
    evt_i = '0;
    wr(3'd0, 32'h0000_0005);
    rd(3'd0);
    chk("R2 partial write-one clear", r0, 32'h0000_000A);
    wr_with_evt(3'd0, 32'h0000_0003, 0);
    rd(3'd0);
    chk("R2 event wins over clear", r0, 32'h0000_0009);
    wr(3'd0, 32'h0000_00FF);
    rd(3'd0);
    chk("R2 clear all", r0, 32'h0);
  endtask

  task automatic t_race;
    wr(3'd1, 32'h0003_0000);
    pulse(8);
    idle(2);
    rd(3'd1);
    snap = r0;
    chk("R3 pipe1 register word", snap, 32'h0003_0001);
    pulse(9);
    wr(3'd1, 32'h0003_0000 | (snap & 32'hFF));
    wr(3'd3, 32'h2);
    idle(2);
    rd(3'd3);
    chk("R7 identity lost after race", r0, 32'h0);
    rd(3'd2);
    chk("R7 live still high after race", r0, 32'h2);
    chk("R7 irq quiet after race", {31'b0, irq0}, 32'h0);
    wr(3'd1, snap & 32'hFF);
    wr(3'd1, 32'h0003_0000);
    idle(2);
    rd(3'd3);
    chk("R8 re-armed identity pipe1", r0, 32'h2);
    chk("R10 irq after re-arm", {31'b0, irq0}, 32'h1);
  endtask

  task automatic t_mask;
    wr(3'd4, 32'h2);
    idle(2);
    chk("R10 masked pipe silences irq", {31'b0, irq0}, 32'h0);
    rd(3'd4);
    chk("R10 mask readback", r0, 32'h2);
    wr(3'd4, 32'h0);
    idle(2);
    chk("R10 unmask restores irq", {31'b0, irq0}, 32'h1);
  endtask

  task automatic t_read_side_effects;
    logic [31:0] first;
    rd(3'd3);
    first = r0;
    rd(3'd3);
    chk("R11 identity read repeatable", r0, first);
    rd(3'd1);
    first = r0;
    rd(3'd1);
    chk("R11 status read repeatable", r0, first);
    idle(3);
    chk("R11 rd_data holds between reads", rdat0, first);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sticky_and_edge();
    t_toggle();
    t_status_clear();
    t_race();
    t_mask();
    t_read_side_effects();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule